// File: doc/BRIEF.md
# Decode-Stage Branch Direction Predictor

This block predicts the direction of conditional branches with a table of two-bit saturating counters. The fetch PC selects one counter. A decode-side stage presents a fetched instruction together with the branch flag and the 16-bit word offset from the decoder. The block then reports whether the branch is predicted taken and computes the branch target. The target is the branch PC plus the offset, sign-extended and scaled to bytes.

An earlier fetch-stage target buffer may already have steered fetch. The block receives that buffer's decision and target. It raises a redirect only when it predicts taken and the earlier buffer did not already send fetch to the same target. When a branch resolves in execute, the pipeline returns the branch PC and the real outcome. The matching counter moves one step on the next clock edge. A lookup never writes the table.

Top module: `bhp_decode_predictor`

## Requirements
- R1: After reset every counter is weakly not-taken (encoding 2'b01). A fresh lookup predicts not taken, and one taken update makes that entry predict taken.
- R2: The counter index is PC bits [IDX_W+1:2]. PCs that differ only in bits [1:0], or only above bit IDX_W+1, share a counter. PCs that differ in the index bits do not share one.
- R3: Counter encoding is 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken, 11 strongly taken. The predicted direction is the counter's upper bit.
- R4: A taken update saturates at strongly taken. After any number of taken updates, exactly two not-taken updates are needed to flip the prediction to not taken.
- R5: A not-taken update saturates at strongly not-taken. After any number of not-taken updates, exactly two taken updates are needed to flip the prediction to taken.
- R6: From a strong state, a single opposite outcome leaves the predicted direction unchanged.
- R7: `pred_target_o` equals the lookup PC plus the 16-bit offset, sign-extended and shifted left by 2, with the sum wrapping modulo 2^32.
- R8: When a valid conditional branch is predicted taken and the fetch buffer did not predict taken, `redirect_o` is 1 and `redirect_pc_o` equals the computed target. A branch predicted not taken never redirects.
- R9: No redirect is raised when the fetch buffer predicted taken with exactly the computed target. A redirect is raised when the fetch buffer predicted taken with a different target.
- R10: When the lookup is not valid, or the instruction is not a conditional branch, both `pred_taken_o` and `redirect_o` are 0.
- R11: If an update and a lookup hit the same entry in one cycle, the lookup sees the old counter. The new value is visible from the next cycle.
- R12: Lookups never change counters. Only updates from execute resolution write the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_valid_i | input | 1 | Decode-stage lookup valid |
| lk_pc_i | input | 32 | PC of the instruction being looked up |
| lk_is_br_i | input | 1 | Instruction is a conditional branch |
| lk_offset_i | input | 16 | Branch word offset from the instruction |
| btb_taken_i | input | 1 | Fetch-stage buffer predicted taken |
| btb_target_i | input | 32 | Target the fetch-stage buffer steered to |
| upd_valid_i | input | 1 | Resolved branch update valid |
| upd_pc_i | input | 32 | PC of the resolved branch |
| upd_taken_i | input | 1 | Real outcome of the resolved branch |
| pred_taken_o | output | 1 | Branch predicted taken |
| pred_target_o | output | 32 | Computed branch target |
| redirect_o | output | 1 | Request a fetch redirect |
| redirect_pc_o | output | 32 | Redirect destination |

## Verification
The hardest case to reach from the ports is the saturation boundary. Counters can only be read through a single direction bit, so a wrap from strongly taken to strongly not-taken would look like correct behaviour unless the state is pushed past the end and then probed. The bench drives several extra same-direction updates into one entry. It then applies opposite outcomes one at a time and checks after each one that the flip happens on exactly the second. It also places an update and a lookup to the same entry in one cycle, and samples before and after the clock edge.

// File: rtl/bhp_pkg.sv
package bhp_pkg;
  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  localparam ctr_e CTR_RESET = CTR_WNT;

  // saturating step toward the observed outcome
  function automatic ctr_e ctr_next(input ctr_e cur, input logic taken);
    ctr_e nxt;
    nxt = cur;
    if (taken) begin
      if (cur != CTR_ST) nxt = ctr_e'(cur + 2'd1);
    end else begin
      if (cur != CTR_SNT) nxt = ctr_e'(cur - 2'd1);
    end
    return nxt;
  endfunction
endpackage

// File: rtl/bhp_counter_table.sv
module bhp_counter_table
  import bhp_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output ctr_e             rd_ctr_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_taken_i
);
  localparam int ENTRIES = 1 << IDX_W;

  ctr_e tbl_q [ENTRIES];
  ctr_e wr_nxt;

  assign wr_nxt   = ctr_next(tbl_q[wr_idx_i], wr_taken_i);
  // read is combinational on the old contents; writes land at the edge
  assign rd_ctr_o = tbl_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= CTR_RESET;
    end else if (wr_en_i) begin
      tbl_q[wr_idx_i] <= wr_nxt;
    end
  end
endmodule

// File: rtl/bhp_target_unit.sv
module bhp_target_unit #(
  parameter int PC_W  = 32,
  parameter int OFF_W = 16
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFF_W-1:0] offset_i,
  output logic [PC_W-1:0]  target_o
);
  localparam int EXT_W = PC_W - OFF_W - 2;

  logic [PC_W-1:0] byte_off;

  generate
    if (EXT_W > 0) begin : g_ext
      assign byte_off = {{EXT_W{offset_i[OFF_W-1]}}, offset_i, 2'b00};
    end else begin : g_trunc
      logic [OFF_W+1:0] full_off;
      assign full_off = {offset_i, 2'b00};
      assign byte_off = full_off[PC_W-1:0];
    end
  endgenerate

  assign target_o = pc_i + byte_off;
endmodule

// File: rtl/bhp_redirect_ctl.sv
module bhp_redirect_ctl #(
  parameter int PC_W = 32
) (
  input  logic            lk_valid_i,
  input  logic            lk_is_br_i,
  input  logic            ctr_taken_i,
  input  logic            btb_taken_i,
  input  logic [PC_W-1:0] btb_target_i,
  input  logic [PC_W-1:0] target_i,
  output logic            pred_taken_o,
  output logic            redirect_o
);
  logic btb_covered;

  assign pred_taken_o = lk_valid_i && lk_is_br_i && ctr_taken_i;
  assign btb_covered  = btb_taken_i && (btb_target_i == target_i);
  assign redirect_o   = pred_taken_o && !btb_covered;
endmodule

// File: rtl/bhp_decode_predictor.sv
module bhp_decode_predictor
  import bhp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 12,
  parameter int OFF_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_valid_i,
  input  logic [PC_W-1:0]  lk_pc_i,
  input  logic             lk_is_br_i,
  input  logic [OFF_W-1:0] lk_offset_i,
  input  logic             btb_taken_i,
  input  logic [PC_W-1:0]  btb_target_i,
  input  logic             upd_valid_i,
  input  logic [PC_W-1:0]  upd_pc_i,
  input  logic             upd_taken_i,
  output logic             pred_taken_o,
  output logic [PC_W-1:0]  pred_target_o,
  output logic             redirect_o,
  output logic [PC_W-1:0]  redirect_pc_o
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_LO + IDX_W - 1;

  logic [IDX_W-1:0] rd_idx, wr_idx;
  ctr_e             rd_ctr;
  logic [PC_W-1:0]  target;

  assign rd_idx = lk_pc_i[IDX_HI:IDX_LO];
  assign wr_idx = upd_pc_i[IDX_HI:IDX_LO];

  bhp_counter_table #(.IDX_W(IDX_W)) i_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (rd_idx),
    .rd_ctr_o   (rd_ctr),
    .wr_en_i    (upd_valid_i),
    .wr_idx_i   (wr_idx),
    .wr_taken_i (upd_taken_i)
  );

  bhp_target_unit #(.PC_W(PC_W), .OFF_W(OFF_W)) i_target (
    .pc_i     (lk_pc_i),
    .offset_i (lk_offset_i),
    .target_o (target)
  );

  bhp_redirect_ctl #(.PC_W(PC_W)) i_redirect (
    .lk_valid_i   (lk_valid_i),
    .lk_is_br_i   (lk_is_br_i),
    .ctr_taken_i  (rd_ctr[1]),
    .btb_taken_i  (btb_taken_i),
    .btb_target_i (btb_target_i),
    .target_i     (target),
    .pred_taken_o (pred_taken_o),
    .redirect_o   (redirect_o)
  );

  assign pred_target_o = target;
  assign redirect_pc_o = target;
endmodule

// File: rtl/bhp_decode_predictor_chk.sv
module bhp_decode_predictor_chk #(
  parameter int PC_W  = 32,
  parameter int OFF_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lk_valid_i,
  input logic [PC_W-1:0]  lk_pc_i,
  input logic             lk_is_br_i,
  input logic [OFF_W-1:0] lk_offset_i,
  input logic             btb_taken_i,
  input logic [PC_W-1:0]  btb_target_i,
  input logic             upd_valid_i,
  input logic [PC_W-1:0]  upd_pc_i,
  input logic             upd_taken_i,
  input logic             pred_taken_o,
  input logic [PC_W-1:0]  pred_target_o,
  input logic             redirect_o,
  input logic [PC_W-1:0]  redirect_pc_o
);
  p_redirect_needs_pred_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> pred_taken_o);

  p_redirect_dest_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (redirect_pc_o == pred_target_o));

  p_btb_hit_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (btb_taken_i && btb_target_i == pred_target_o) |-> !redirect_o);

  p_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lk_valid_i && lk_is_br_i) |-> !(pred_taken_o || redirect_o));

  // with no update last cycle, a repeated lookup must give the same direction
  p_lookup_no_write_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && lk_is_br_i && $past(lk_valid_i) && $past(lk_is_br_i) &&
     lk_pc_i == $past(lk_pc_i) && !$past(upd_valid_i))
    |-> (pred_taken_o == $past(pred_taken_o)));

  p_target_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(lk_pc_i) && $stable(lk_offset_i)) |-> $stable(pred_target_o));
endmodule

bind bhp_decode_predictor bhp_decode_predictor_chk #(.PC_W(PC_W), .OFF_W(OFF_W)) i_chk (.*);

// File: tb/test_bhp_decode_predictor.sv
module test_bhp_decode_predictor;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W      = 12;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lk_valid_i = 1'b0;
  logic [31:0] lk_pc_i = '0;
  logic        lk_is_br_i = 1'b0;
  logic [15:0] lk_offset_i = '0;
  logic        btb_taken_i = 1'b0;
  logic [31:0] btb_target_i = '0;
  logic        upd_valid_i = 1'b0;
  logic [31:0] upd_pc_i = '0;
  logic        upd_taken_i = 1'b0;
  logic        pred_taken_o;
  logic [31:0] pred_target_o;
  logic        redirect_o;
  logic [31:0] redirect_pc_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bhp_decode_predictor #(.PC_W(32), .IDX_W(IDX_W), .OFF_W(16)) i_bhp_decode_predictor (
    .clk_i, .rst_ni, .lk_valid_i, .lk_pc_i, .lk_is_br_i, .lk_offset_i,
    .btb_taken_i, .btb_target_i, .upd_valid_i, .upd_pc_i, .upd_taken_i,
    .pred_taken_o, .pred_target_o, .redirect_o, .redirect_pc_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] pc, input logic [15:0] off = 16'h0004,
                      input logic bt = 1'b0, input logic [31:0] btgt = '0);
    @(negedge clk_i);
    lk_valid_i = 1'b1; lk_is_br_i = 1'b1; lk_pc_i = pc; lk_offset_i = off;
    btb_taken_i = bt; btb_target_i = btgt;
    #1;
  endtask

  task automatic upd(input logic [31:0] pc, input logic taken, input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      upd_valid_i = 1'b1; upd_pc_i = pc; upd_taken_i = taken;
    end
    @(negedge clk_i);
    upd_valid_i = 1'b0;
  endtask

  task automatic t_reset_state;
    look(32'h0000_0100);
    chk("R1 reset predict", {31'd0, pred_taken_o}, 32'd0);
    chk("R1 reset redirect", {31'd0, redirect_o}, 32'd0);
    upd(32'h0000_0100, 1'b1);
    look(32'h0000_0100);
    chk("R1 one taken flips weak NT", {31'd0, pred_taken_o}, 32'd1);
    chk("R3 weak taken upper bit", {31'd0, pred_taken_o}, 32'd1);
  endtask

  task automatic t_sat_taken;
    upd(32'h0000_0200, 1'b1, 6);
    upd(32'h0000_0200, 1'b0);
    look(32'h0000_0200);
    chk("R6 one NT from strong T", {31'd0, pred_taken_o}, 32'd1);
    upd(32'h0000_0200, 1'b0);
    look(32'h0000_0200);
    chk("R4 second NT flips", {31'd0, pred_taken_o}, 32'd0);
  endtask

  task automatic t_sat_nt;
    upd(32'h0000_0300, 1'b0, 6);
    upd(32'h0000_0300, 1'b1);
    look(32'h0000_0300);
    chk("R6 one T from strong NT", {31'd0, pred_taken_o}, 32'd0);
    upd(32'h0000_0300, 1'b1);
    look(32'h0000_0300);
    chk("R5 second T flips", {31'd0, pred_taken_o}, 32'd1);
  endtask

  task automatic t_index;
    upd(32'h0000_0400, 1'b1);
    look(32'h0000_0404);
    chk("R2 neighbour entry", {31'd0, pred_taken_o}, 32'd0);
    look(32'h0000_0400 + (32'd1 << (IDX_W + 2)));
    chk("R2 upper alias", {31'd0, pred_taken_o}, 32'd1);
    look(32'h0000_0402);
    chk("R2 low bits ignored", {31'd0, pred_taken_o}, 32'd1);
  endtask

  task automatic t_target;
    look(32'h0000_1000, 16'h0010);
    chk("R7 positive offset", pred_target_o, 32'h0000_1040);
    look(32'h0000_1000, 16'hFFFE);
    chk("R7 negative offset", pred_target_o, 32'h0000_0FF8);
    look(32'h0004_0000, 16'h8000);
    chk("R7 most negative", pred_target_o, 32'h0002_0000);
    look(32'hFFFF_FFF0, 16'h0008);
    chk("R7 wrap", pred_target_o, 32'h0000_0010);
  endtask

  task automatic t_redirect;
    upd(32'h0000_0700, 1'b1);
    look(32'h0000_0700, 16'h0020);
    chk("R8 redirect on miss", {31'd0, redirect_o}, 32'd1);
    chk("R8 redirect pc", redirect_pc_o, 32'h0000_0780);
    look(32'h0000_0700, 16'h0020, 1'b1, 32'h0000_0780);
    chk("R9 buffer hit same target", {31'd0, redirect_o}, 32'd0);
    look(32'h0000_0700, 16'h0020, 1'b1, 32'h0000_0784);
    chk("R9 buffer hit wrong target", {31'd0, redirect_o}, 32'd1);
    look(32'h0000_0800, 16'h0020);
    chk("R8 predicted NT no redirect", {31'd0, redirect_o}, 32'd0);
  endtask

  task automatic t_gating;
    look(32'h0000_0700, 16'h0020);
    lk_valid_i = 1'b0; #1;
    chk("R10 invalid pred", {31'd0, pred_taken_o}, 32'd0);
    chk("R10 invalid redirect", {31'd0, redirect_o}, 32'd0);
    lk_valid_i = 1'b1; lk_is_br_i = 1'b0; #1;
    chk("R10 non-branch pred", {31'd0, pred_taken_o}, 32'd0);
    chk("R10 non-branch redirect", {31'd0, redirect_o}, 32'd0);
  endtask

  task automatic t_same_cycle;
    look(32'h0000_0500);
    upd_valid_i = 1'b1; upd_pc_i = 32'h0000_0500; upd_taken_i = 1'b1; #1;
    chk("R11 old value same cycle", {31'd0, pred_taken_o}, 32'd0);
    @(negedge clk_i);
    upd_valid_i = 1'b0; #1;
    chk("R11 new value next cycle", {31'd0, pred_taken_o}, 32'd1);
  endtask

  task automatic t_lookup_no_write;
    for (int i = 0; i < 6; i++) look(32'h0000_0600);
    chk("R12 repeated lookups", {31'd0, pred_taken_o}, 32'd0);
    upd(32'h0000_0600, 1'b1);
    look(32'h0000_0600);
    chk("R12 still weak NT", {31'd0, pred_taken_o}, 32'd1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset_state();
    t_sat_taken();
    t_sat_nt();
    t_index();
    t_target();
    t_redirect();
    t_gating();
    t_same_cycle();
    t_lookup_no_write();
    finish_run();
  end
endmodule